// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands and turns the result into a two-bit ordering code. The operands arrive as raw bit patterns and are never converted. A nine-bit function code selects one of four operations: a single-precision or a double-precision compare, each in a quiet form and in a signalling form. The block merges the ordering code into a copy of a 32-bit status word. Every other status bit passes through untouched.

A caller presents the function code, both operands, the current status word and a one-cycle valid strobe. One clock later the block returns the updated status word, the code on its own, and a done pulse. It also raises one of two flags: an invalid-operation trap when a signalling compare meets a NaN, or an illegal-operation flag when the function code is not one of the four compares. Operand storage and arithmetic stay with the caller.

Top module: `fpcc_unit`

## Requirements
- R1: Function code 0x51 is a quiet single compare and 0x52 a quiet double compare. Function code 0x55 is a signalling single compare and 0x56 a signalling double compare. Single compares read only bits 31:0 of each operand and ignore bits 63:32.
- R2: The ordering code is 0 when the operands are equal, 1 when A is less than B, 2 when A is greater than B, and 3 when they are unordered.
- R3: For a quiet compare, an operand with an all-ones exponent and a nonzero mantissa is a NaN, and the code is 3. An all-ones exponent with a zero mantissa is an infinity and is ordered normally.
- R4: For a signalling compare with a NaN operand, `trap_invalid_o` is 1, `status_o` equals `status_i` unchanged, and `cc_o` keeps its previous value.
- R5: After a compare that completes, bits 11:10 of `status_o` hold the ordering code and every other bit equals `status_i`.
- R6: Any other function code sets `illegal_o`, leaves `status_o` equal to `status_i`, and keeps `cc_o`. `illegal_o` and `trap_invalid_o` are never both 1.
- R7: Positive zero and negative zero compare as equal in both precisions.
- R8: Between non-NaN operands of different sign, the negative one is less. When both operands are negative, the larger magnitude is the lesser value.
- R9: All outputs are registered. `done_o` pulses for exactly one cycle, one clock after `valid_i`. While `valid_i` is low, `status_o`, `cc_o` and the flags hold their values.
- R10: Synchronous active-high reset clears `status_o`, `cc_o`, `done_o`, `trap_invalid_o` and `illegal_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | One-cycle request strobe |
| opf_i | input | 9 | Function code |
| src_a_i | input | 64 | Operand A bit pattern (single precision in bits 31:0) |
| src_b_i | input | 64 | Operand B bit pattern (single precision in bits 31:0) |
| status_i | input | 32 | Current status word |
| status_o | output | 32 | Status word with the code merged into bits 11:10 |
| cc_o | output | 2 | Last ordering code produced |
| done_o | output | 1 | Result-valid pulse |
| trap_invalid_o | output | 1 | Signalling compare met a NaN |
| illegal_o | output | 1 | Function code not recognised |

## Verification
The bench compares signed zeros against each other. A design that compares raw bits would report them as unequal. It also orders pairs of negative numbers, where a design without the magnitude reversal would return less and greater the wrong way round. Infinities are paired with NaNs that carry only a single mantissa bit, so a NaN test that looks only at the exponent, or only at the top mantissa bit, shows up as a wrong code. Single compares are run with nonzero upper operand bits, to catch a design that reads the wrong half or the double comparator. Signalling and unknown function codes are checked to leave the status word and the previous code untouched.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int OPF_W   = 9;
    localparam int OPND_W  = 64;
    localparam int STAT_W  = 32;
    localparam int CC_W    = 2;
    localparam int CC_LO   = 10;
    localparam int CC_HI   = CC_LO + CC_W - 1;

    localparam int SGL_EXP_W = 8;
    localparam int SGL_MAN_W = 23;
    localparam int DBL_EXP_W = 11;
    localparam int DBL_MAN_W = 52;
    localparam int SGL_W     = SGL_EXP_W + SGL_MAN_W + 1;
    localparam int DBL_W     = DBL_EXP_W + DBL_MAN_W + 1;

    localparam logic [OPF_W-1:0] OPF_QCMP_S = 9'h051;
    localparam logic [OPF_W-1:0] OPF_QCMP_D = 9'h052;
    localparam logic [OPF_W-1:0] OPF_XCMP_S = 9'h055;
    localparam logic [OPF_W-1:0] OPF_XCMP_D = 9'h056;

    typedef enum logic [CC_W-1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } cc_e;

    typedef struct packed {
        logic known;
        logic dbl;
        logic signalling;
    } op_kind_t;

    typedef struct packed {
        logic nan;
        cc_e  cc;
    } cmp_res_t;

    function automatic op_kind_t decode_opf(input logic [OPF_W-1:0] opf);
        op_kind_t k;
        k = '0;
        unique case (opf)
            OPF_QCMP_S: k = '{known: 1'b1, dbl: 1'b0, signalling: 1'b0};
            OPF_QCMP_D: k = '{known: 1'b1, dbl: 1'b1, signalling: 1'b0};
            OPF_XCMP_S: k = '{known: 1'b1, dbl: 1'b0, signalling: 1'b1};
            OPF_XCMP_D: k = '{known: 1'b1, dbl: 1'b1, signalling: 1'b1};
            default:    k = '0;
        endcase
        return k;
    endfunction

    function automatic logic [STAT_W-1:0] merge_cc(input logic [STAT_W-1:0] st,
                                                   input cc_e cc);
        logic [STAT_W-1:0] r;
        r = st;
        r[CC_HI:CC_LO] = cc;
        return r;
    endfunction

endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
    import fpcc_pkg::*;
(
    input  logic [OPF_W-1:0] opf_i,
    output op_kind_t         kind_o
);
    always_comb begin
        kind_o = decode_opf(opf_i);
    end

    always_comb begin
        if (kind_o.dbl || kind_o.signalling)
            assert_kind_known_R6: assert (kind_o.known);
    end
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
    import fpcc_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = EXP_W + MAN_W + 1
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output cmp_res_t     res_o
);
    logic             sgn_a, sgn_b;
    logic [W-2:0]     mag_a, mag_b;
    logic             nan_a, nan_b;
    logic             zero_both;
    logic             mag_lt;
    logic             a_less;

    assign sgn_a = a_i[W-1];
    assign sgn_b = b_i[W-1];
    assign mag_a = a_i[W-2:0];
    assign mag_b = b_i[W-2:0];
    assign nan_a = (&a_i[W-2:MAN_W]) && (|a_i[MAN_W-1:0]);
    assign nan_b = (&b_i[W-2:MAN_W]) && (|b_i[MAN_W-1:0]);
    assign zero_both = (mag_a == '0) && (mag_b == '0);
    assign mag_lt = mag_a < mag_b;

    always_comb begin
        if (sgn_a != sgn_b) a_less = sgn_a;
        else if (sgn_a)     a_less = !mag_lt;
        else                a_less = mag_lt;
    end

    always_comb begin
        res_o.nan = nan_a || nan_b;
        if (nan_a || nan_b)                   res_o.cc = CC_UN;
        else if (zero_both || (a_i == b_i))   res_o.cc = CC_EQ;
        else if (a_less)                      res_o.cc = CC_LT;
        else                                  res_o.cc = CC_GT;
    end

    always_comb begin
        if (zero_both)
            assert_signed_zero_equal_R7: assert (res_o.cc == CC_EQ);
        if (res_o.cc == CC_UN)
            assert_unordered_only_nan_R3: assert (nan_a || nan_b);
    end
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
    import fpcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [8:0]        opf_i,
    input  logic [63:0]       src_a_i,
    input  logic [63:0]       src_b_i,
    input  logic [31:0]       status_i,
    output logic [31:0]       status_o,
    output logic [1:0]        cc_o,
    output logic              done_o,
    output logic              trap_invalid_o,
    output logic              illegal_o
);
    localparam int NFMT = 2;

    op_kind_t  kind;
    cmp_res_t  fmt_res [NFMT];
    cmp_res_t  sel_res;
    logic      do_trap;
    logic      do_write;

    fpcc_decode u_dec (
        .opf_i  (opf_i),
        .kind_o (kind)
    );

    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        localparam int EW = (g == 0) ? SGL_EXP_W : DBL_EXP_W;
        localparam int MW = (g == 0) ? SGL_MAN_W : DBL_MAN_W;
        localparam int FW = EW + MW + 1;
        fpcc_order #(.EXP_W(EW), .MAN_W(MW)) u_ord (
            .a_i   (src_a_i[FW-1:0]),
            .b_i   (src_b_i[FW-1:0]),
            .res_o (fmt_res[g])
        );
    end

    assign sel_res  = kind.dbl ? fmt_res[1] : fmt_res[0];
    assign do_trap  = kind.known && kind.signalling && sel_res.nan;
    assign do_write = kind.known && !do_trap;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o       <= '0;
            cc_o           <= '0;
            done_o         <= 1'b0;
            trap_invalid_o <= 1'b0;
            illegal_o      <= 1'b0;
        end else begin
            done_o <= valid_i;
            if (valid_i) begin
                trap_invalid_o <= do_trap;
                illegal_o      <= !kind.known;
                if (do_write) begin
                    cc_o     <= sel_res.cc;
                    status_o <= merge_cc(status_i, sel_res.cc);
                end else begin
                    status_o <= status_i;
                end
            end
        end
    end

    assert_done_latency_R9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !done_o);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(status_o) && $stable(cc_o)));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({trap_invalid_o, illegal_o}) <= 1);

    assert_trap_no_update_R4: assert property (@(posedge clk) disable iff (rst)
        (done_o && trap_invalid_o) |-> (status_o == $past(status_i) && $stable(cc_o)));

    assert_illegal_no_update_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && illegal_o) |-> (status_o == $past(status_i) && $stable(cc_o)));

    assert_merge_field_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !trap_invalid_o && !illegal_o) |->
            (status_o[11:10] == cc_o &&
             status_o[31:12] == $past(status_i[31:12]) &&
             status_o[9:0]   == $past(status_i[9:0])));
endmodule

// File: tb/fpcc_unit_test.sv
module fpcc_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [8:0]  opf_i;
    logic [63:0] src_a_i, src_b_i;
    logic [31:0] status_i;
    logic [31:0] status_o;
    logic [1:0]  cc_o;
    logic        done_o, trap_invalid_o, illegal_o;

    int checks = 0;
    int fails  = 0;
    logic [1:0] exp_cc = 2'd0;

    always #5 clk = ~clk;

    fpcc_unit uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .opf_i(opf_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .status_i(status_i),
        .status_o(status_o), .cc_o(cc_o), .done_o(done_o),
        .trap_invalid_o(trap_invalid_o), .illegal_o(illegal_o)
    );

    typedef struct packed {
        logic [8:0]  opf;
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  cc;
        logic        trap;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] HI = 64'hDEAD_BEEF_0000_0000;
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{9'h051, HI|64'h3F800000, HI|64'h40000000, 2'd1, 1'b0, 1'b0, 8'd2},
        '{9'h051, HI|64'h40000000, HI|64'h3F800000, 2'd2, 1'b0, 1'b0, 8'd2},
        '{9'h051, HI|64'h3F800000, 64'h3F800000,    2'd0, 1'b0, 1'b0, 8'd1},
        '{9'h051, 64'h00000000,    64'h80000000,    2'd0, 1'b0, 1'b0, 8'd7},
        '{9'h051, 64'hBF800000,    64'h3F800000,    2'd1, 1'b0, 1'b0, 8'd8},
        '{9'h051, 64'hBF800000,    64'hC0000000,    2'd2, 1'b0, 1'b0, 8'd8},
        '{9'h051, 64'hC0000000,    64'hBF800000,    2'd1, 1'b0, 1'b0, 8'd8},
        '{9'h051, 64'h7F800001,    64'h3F800000,    2'd3, 1'b0, 1'b0, 8'd3},
        '{9'h051, 64'h3F800000,    64'h7FC00000,    2'd3, 1'b0, 1'b0, 8'd3},
        '{9'h051, 64'h7F800000,    64'h3F800000,    2'd2, 1'b0, 1'b0, 8'd3},
        '{9'h051, 64'hFF800000,    64'hBF800000,    2'd1, 1'b0, 1'b0, 8'd3},
        '{9'h052, 64'h3FF0000000000000, 64'h4000000000000000, 2'd1, 1'b0, 1'b0, 8'd1},
        '{9'h052, 64'h0000000000000000, 64'h8000000000000000, 2'd0, 1'b0, 1'b0, 8'd7},
        '{9'h052, 64'hC000000000000000, 64'hBFF0000000000000, 2'd1, 1'b0, 1'b0, 8'd8},
        '{9'h052, 64'h3FF0000000000000, 64'h3FF0000000000001, 2'd1, 1'b0, 1'b0, 8'd1},
        '{9'h052, 64'h7FF0000000000001, 64'h0000000000000000, 2'd3, 1'b0, 1'b0, 8'd3},
        '{9'h055, 64'h40000000,    64'h3F800000,    2'd2, 1'b0, 1'b0, 8'd1},
        '{9'h055, 64'h7F800001,    64'h3F800000,    2'd0, 1'b1, 1'b0, 8'd4},
        '{9'h056, 64'h8000000000000000, 64'h0000000000000000, 2'd0, 1'b0, 1'b0, 8'd7},
        '{9'h056, 64'h3FF0000000000000, 64'h7FF8000000000000, 2'd0, 1'b1, 1'b0, 8'd4},
        '{9'h053, 64'h3F800000,    64'h40000000,    2'd0, 1'b0, 1'b1, 8'd6},
        '{9'h151, 64'h3F800000,    64'h40000000,    2'd0, 1'b0, 1'b1, 8'd6}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [8:0] opf, input logic [63:0] a,
                         input logic [63:0] b, input logic [31:0] st);
        @(negedge clk);
        valid_i  = 1'b1;
        opf_i    = opf;
        src_a_i  = a;
        src_b_i  = b;
        status_i = st;
        @(negedge clk);
        valid_i  = 1'b0;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] st;
        logic [31:0] exp_st;
        string tag;
        rst = 1'b1; valid_i = 1'b0; opf_i = '0;
        src_a_i = '0; src_b_i = '0; status_i = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "status", status_o, 32'h0);
        check("R10", "cc", {30'b0, cc_o}, 32'h0);
        check("R10", "flags", {29'b0, done_o, trap_invalid_o, illegal_o}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            st = 32'h5A5A_0000 ^ (32'h0000_1C03 << (i % 4));
            apply(VECS[i].opf, VECS[i].a, VECS[i].b, st);
            tag = $sformatf("R%0d", VECS[i].req);
            if (!VECS[i].trap && !VECS[i].ill) begin
                exp_cc = VECS[i].cc;
                exp_st = {st[31:12], VECS[i].cc, st[9:0]};
            end else begin
                exp_st = st;
            end
            check(tag, $sformatf("vec%0d cc", i), {30'b0, cc_o}, {30'b0, exp_cc});
            check("R5", $sformatf("vec%0d status", i), status_o, exp_st);
            check(VECS[i].trap ? "R4" : "R6", $sformatf("vec%0d trap/illegal", i),
                  {30'b0, trap_invalid_o, illegal_o}, {30'b0, VECS[i].trap, VECS[i].ill});
            check("R9", $sformatf("vec%0d done", i), {31'b0, done_o}, 32'd1);
        end

        // R9 hold while idle and single-cycle done pulse
        status_i = 32'h1234_5678;
        @(negedge clk);
        check("R9", "done low when idle", {31'b0, done_o}, 32'd0);
        check("R9", "status held when idle", status_o, 32'h5A5A_0000 ^ (32'h0000_1C03 << ((NV-1) % 4)));
        check("R9", "cc held when idle", {30'b0, cc_o}, {30'b0, exp_cc});

        // R1 single compare ignores differing upper bits: equal lows
        apply(9'h051, 64'hFFFF_FFFF_C0000000, 64'h0000_0001_C0000000, 32'h0);
        check("R1", "upper bits ignored", {30'b0, cc_o}, 32'd0);
        check("R5", "status bits 11:10", status_o, 32'h0);

        // R8 negative vs positive zero-adjacent: -tiny < +tiny
        apply(9'h051, 64'h80000001, 64'h00000001, 32'hFFFF_FFFF);
        check("R8", "neg denormal less", {30'b0, cc_o}, 32'd1);
        check("R5", "status merge all ones", status_o, 32'hFFFF_F7FF);

        // R4 trap then a clean compare recovers
        apply(9'h056, 64'h7FF0000000000001, 64'h7FF0000000000001, 32'h0000_0C00);
        check("R4", "trap status untouched", status_o, 32'h0000_0C00);
        check("R4", "trap cc kept", {30'b0, cc_o}, 32'd1);
        apply(9'h055, 64'h3F800000, 64'h3F800000, 32'h0000_0C00);
        check("R2", "equal after trap", {30'b0, cc_o}, 32'd0);
        check("R4", "trap cleared", {31'b0, trap_invalid_o}, 32'd0);

        // R10 reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", "status after reset", status_o, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule